// File: doc/BRIEF.md
# Dual Interval Timer

This block holds two 16-bit down-counters that a CPU programs over a byte-wide register bus. Every action is paced by a one-cycle enable, `cyc_en`, that marks one CPU bus cycle. Timer A can run as a one-shot or as a periodic source. Timer B is one-shot only. Each timer reports its expiry in a sticky interrupt flag. A two-bit enable mask decides which flags pull the active-low interrupt line.

The bus is simple. A write to a timer's high byte stores that byte and restarts the timer. The timer then begins its count from the full 16-bit reload value on the following bus cycle. The timing reproduces the classic adapter behaviour:

- The counter passes through 0xFFFF before the flag sets.
- A periodic cycle lasts the reload value plus two bus cycles.
- A reload value of zero still expires.

Top module: `vtim_top`

## Requirements
- R1: A synchronous reset has these effects:
  - It clears both interrupt flags, both enable bits, the periodic-mode bit and the armed state of both timers.
  - It sets both counters and both reload values to 0x0000.
  - It leaves `irq_n` high.
  - The first read of address 0 after reset returns 0x00.
- R2: Address 1 is the timer A high byte. A write there at bus cycle W stores the byte and arms the timer. The full 16-bit reload value (address 0 holds the low byte) is copied into the counter by the enabled edge that ends cycle W+1. A read in cycle W+2 therefore returns the reload value. The count then drops by one per enabled cycle. Addresses 0 and 1 read the counter's low and high bytes.
- R3: An underflow is the counter stepping from 0x0000 to 0xFFFF. The timer A flag is bit 0 of the flag register at address 5. While the counter reads 0xFFFF this flag is still clear. It is set on the next enabled cycle, the cycle in which the counter would read 0xFFFE.
- R4: Periodic mode is selected when bit 0 of the mode register at address 4 is 1. In this mode timer A reloads from its reload value on the cycle after 0xFFFF, giving a period of the reload value plus 2 cycles. The flag sets again on every period.
- R5: In one-shot mode timer A sets its flag once per high-byte write. The counter keeps decrementing through 0xFFFE and below. A later wrap through zero does not set the flag again.
- R6: A write to the timer A high byte clears the timer A flag.
- R7: A read of the timer A counter low byte (address 0) clears the timer A flag.
- R8: Timer B is one-shot only and follows the same sequence as timer A:
  - Address 2 holds its low byte and address 3 its high byte; the high-byte write starts it.
  - Its flag is bit 1 of the flag register.
  - After the flag sets, the counter decrements on without reloading, and later wraps raise no flag.
  - A read of address 2 clears the timer B flag.
- R9: The enable register sits at address 6. On a write to it:
  - If data bit 7 is 1, every enable bit whose data bit is 1 is set. Bit 0 belongs to timer A and bit 1 to timer B.
  - If data bit 7 is 0, every enable bit whose data bit is 1 is cleared.

  A read returns the enables in bits 1:0. `irq_n` is low exactly while some flag and its enable are both set. Bit 7 of the flag register reads 1 in that case.
- R10: A reload value of 0x0000 counts as follows. The counter reads 0x0000 in cycle W+2 and underflows on the edge that ends that cycle. The flag is set when read in cycle W+4.
- R11: Clock edges on which `cyc_en` is low change no counter, flag or register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cyc_en | input | 1 | Bus-cycle enable; one enabled edge per CPU cycle |
| bus_wr | input | 1 | Register write strobe, qualified by `cyc_en` |
| bus_rd | input | 1 | Register read strobe, qualified by `cyc_en`; used for read side effects |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| irq_n | output | 1 | Interrupt request, active low |

## Verification
The bench looks for two kinds of fault in the internal sequence.

- **Off-by-one timing.** A wrong underflow marker or a missing reload delay shifts the flag by one cycle against the counter value. The bench reads the counter and the flag register in the exact cycles around 0xFFFF, so such a fault shows on the very next bus read.
- **Wrong armed state.** A stale armed bit shows only at the next wrap, up to 65536 cycles later. The bench therefore lets each one-shot timer run one full wrap and then reads the flag and `irq_n`.

Enable-mask faults show on `irq_n` in the cycle after the enable write.

// File: rtl/vtim_pkg.sv
package vtim_pkg;

    localparam int BYTE_W   = 8;
    localparam int ADDR_W   = 3;
    localparam int NUM_CHAN = 2;

    typedef enum logic [ADDR_W-1:0] {
        RA_A_LO   = 3'd0,
        RA_A_HI   = 3'd1,
        RA_B_LO   = 3'd2,
        RA_B_HI   = 3'd3,
        RA_MODE   = 3'd4,
        RA_FLAGS  = 3'd5,
        RA_ENABLE = 3'd6,
        RA_SPARE  = 3'd7
    } reg_addr_e;

    typedef struct packed {
        logic wr_lo;
        logic wr_hi;
        logic rd_lo;
    } chan_ctl_t;

    // Channel n owns the address pair 2n (low byte) and 2n+1 (high byte).
    function automatic chan_ctl_t chan_strobes(input logic wr, input logic rd,
                                               input logic [ADDR_W-1:0] a,
                                               input int unsigned idx);
        chan_ctl_t r;
        logic [ADDR_W-1:0] lo_a;
        logic [ADDR_W-1:0] hi_a;
        lo_a = ADDR_W'(2 * idx);
        hi_a = lo_a + ADDR_W'(1);
        r.wr_lo = wr && (a == lo_a);
        r.wr_hi = wr && (a == hi_a);
        r.rd_lo = rd && (a == lo_a);
        return r;
    endfunction

endpackage

// File: rtl/vtim_chan.sv
module vtim_chan #(
    parameter int CNT_W    = 16,
    parameter int BYTE_W   = 8,
    parameter bit FREE_CAP = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              free_run,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic              rd_lo,
    input  logic [BYTE_W-1:0] wdata,
    output logic [CNT_W-1:0]  count,
    output logic              flag
);
    localparam int HI_W = CNT_W - BYTE_W;
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] latch;
        logic             uf_pend;   // counter holds 0xFFFF reached by underflow
        logic             load_pend; // high byte written last cycle
        logic             armed;
        logic             flag;
    } chan_st_t;

    chan_st_t st_q, st_d;
    logic reload;
    logic fire;

    assign reload = FREE_CAP && free_run;
    assign fire   = st_q.uf_pend && st_q.armed;

    always_comb begin
        st_d = st_q;
        if (tick) begin
            if (wr_lo) st_d.latch[BYTE_W-1:0] = wdata;
            if (wr_hi) begin
                st_d.latch[CNT_W-1:BYTE_W] = wdata[HI_W-1:0];
                st_d.load_pend = 1'b1;
                st_d.armed     = 1'b1;
                st_d.flag      = 1'b0;
                st_d.uf_pend   = 1'b0;
                st_d.cnt       = st_q.cnt - ONE;
            end else begin
                if (st_q.load_pend) begin
                    st_d.cnt       = st_q.latch;
                    st_d.load_pend = 1'b0;
                    st_d.uf_pend   = 1'b0;
                end else if (st_q.uf_pend && reload) begin
                    st_d.cnt     = st_q.latch;
                    st_d.uf_pend = 1'b0;
                end else begin
                    st_d.cnt     = st_q.cnt - ONE;
                    st_d.uf_pend = (st_q.cnt == '0);
                end
                if (fire) begin
                    st_d.flag = 1'b1;
                    if (!reload) st_d.armed = 1'b0;
                end else if (rd_lo) begin
                    st_d.flag = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign count = st_q.cnt;
    assign flag  = st_q.flag;

    // R3
    flag_after_uf_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(st_q.flag) |-> $past(st_q.uf_pend && st_q.armed && tick));

    // R6
    hi_write_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && wr_hi) |=> (!st_q.flag && st_q.armed && st_q.load_pend));

    // R2
    load_value_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && st_q.load_pend && !wr_hi) |=> (st_q.cnt == $past(st_q.latch)));

    // R5
    oneshot_disarm_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && !wr_hi && fire && !reload) |=> !st_q.armed);

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !tick |=> ($stable(st_q.cnt) && $stable(st_q.flag)));

endmodule

// File: rtl/vtim_irq.sv
module vtim_irq #(
    parameter int NCH = 2
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           tick,
    input  logic           en_wr,
    input  logic           set_sel,
    input  logic [NCH-1:0] sel_bits,
    input  logic [NCH-1:0] flags,
    output logic [NCH-1:0] enables,
    output logic           irq_n
);
    logic [NCH-1:0] en_q;

    always_ff @(posedge clk) begin
        if (rst)
            en_q <= '0;
        else if (tick && en_wr)
            en_q <= set_sel ? (en_q | sel_bits) : (en_q & ~sel_bits);
    end

    assign enables = en_q;
    assign irq_n   = ~|(flags & en_q);

    // R9
    en_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(tick && en_wr) |=> $stable(en_q));

    // R9
    en_set_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && en_wr && set_sel) |=> ((en_q & $past(sel_bits)) == $past(sel_bits)));

    // R9
    en_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && en_wr && !set_sel) |=> ((en_q & $past(sel_bits)) == '0));

endmodule

// File: rtl/vtim_top.sv
module vtim_top
    import vtim_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cyc_en,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    output logic              irq_n
);
    localparam int PAD_W = BYTE_W - 1 - NUM_CHAN;

    logic                free_run_q;
    logic [CNT_W-1:0]    ch_cnt [NUM_CHAN];
    logic [NUM_CHAN-1:0] ch_flag;
    logic [NUM_CHAN-1:0] en_bits;
    logic                en_wr;
    logic [CNT_W-1:0]    sel_cnt;

    always_ff @(posedge clk) begin
        if (rst)
            free_run_q <= 1'b0;
        else if (cyc_en && bus_wr && bus_addr == RA_MODE)
            free_run_q <= bus_wdata[0];
    end

    for (genvar i = 0; i < NUM_CHAN; i++) begin : g_ch
        chan_ctl_t ctl;
        assign ctl = chan_strobes(bus_wr, bus_rd, bus_addr, i);
        vtim_chan #(
            .CNT_W   (CNT_W),
            .BYTE_W  (BYTE_W),
            .FREE_CAP(i == 0)
        ) u_ch (
            .clk     (clk),
            .rst     (rst),
            .tick    (cyc_en),
            .free_run(free_run_q),
            .wr_lo   (ctl.wr_lo),
            .wr_hi   (ctl.wr_hi),
            .rd_lo   (ctl.rd_lo),
            .wdata   (bus_wdata),
            .count   (ch_cnt[i]),
            .flag    (ch_flag[i])
        );
    end

    assign en_wr = bus_wr && (bus_addr == RA_ENABLE);

    vtim_irq #(.NCH(NUM_CHAN)) u_irq (
        .clk     (clk),
        .rst     (rst),
        .tick    (cyc_en),
        .en_wr   (en_wr),
        .set_sel (bus_wdata[BYTE_W-1]),
        .sel_bits(bus_wdata[NUM_CHAN-1:0]),
        .flags   (ch_flag),
        .enables (en_bits),
        .irq_n   (irq_n)
    );

    assign sel_cnt = ch_cnt[bus_addr[1]];

    always_comb begin
        bus_rdata = '0;
        if (!bus_addr[2]) begin
            bus_rdata = bus_addr[0] ? BYTE_W'(sel_cnt >> BYTE_W) : sel_cnt[BYTE_W-1:0];
        end else begin
            case (reg_addr_e'(bus_addr))
                RA_MODE:   bus_rdata = {{(BYTE_W-1){1'b0}}, free_run_q};
                RA_FLAGS:  bus_rdata = {~irq_n, {PAD_W{1'b0}}, ch_flag};
                RA_ENABLE: bus_rdata = {1'b0, {PAD_W{1'b0}}, en_bits};
                default:   bus_rdata = '0;
            endcase
        end
    end

endmodule

// File: tb/sim_vtim_top.sv
`timescale 1ns/1ps
module sim_vtim_top;
    import vtim_pkg::*;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cyc_en = 1'b0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       irq_n;
    logic       peek = 1'b0;
    bit         done = 1'b0;
    bit         reported = 1'b0;
    int         checks = 0;
    int         errors = 0;

    typedef struct {
        string      req;
        bit         is_irq;
        logic [2:0] addr;
        logic [7:0] exp;
    } item_t;

    item_t sb[$];

    always #2.5 clk = ~clk;

    vtim_top u0 (
        .clk(clk), .rst(rst), .cyc_en(cyc_en), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_n(irq_n)
    );

    // Monitor: pops the scoreboard whenever the driver marks a sampled cycle.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (bus_rd || peek) begin
                item_t it;
                logic [7:0] act;
                checks++;
                if (sb.size() == 0) begin
                    errors++;
                    $display("FAIL scoreboard empty actual=%h expected=item", bus_rdata);
                end else begin
                    it = sb.pop_front();
                    act = it.is_irq ? {7'b0, irq_n} : bus_rdata;
                    if (act !== it.exp) begin
                        errors++;
                        $display("FAIL %s addr=%0d irq=%0d actual=%h expected=%h",
                                 it.req, it.addr, it.is_irq, act, it.exp);
                    end
                end
            end
        end
    end

    task automatic cyc(input logic e, input logic w, input logic r,
                       input logic [2:0] a, input logic [7:0] d, input logic pk);
        cyc_en = e; bus_wr = w; bus_rd = r; bus_addr = a; bus_wdata = d; peek = pk;
        @(negedge clk);
    endtask

    task automatic wr_reg(input reg_addr_e a, input logic [7:0] d);
        cyc(1'b1, 1'b1, 1'b0, a, d, 1'b0);
    endtask

    task automatic rd_chk(input reg_addr_e a, input logic [7:0] e, input string req);
        item_t it;
        it.req = req; it.is_irq = 1'b0; it.addr = a; it.exp = e;
        sb.push_back(it);
        cyc(1'b1, 1'b0, 1'b1, a, 8'h00, 1'b0);
    endtask

    task automatic irq_chk(input logic e, input string req);
        item_t it;
        it.req = req; it.is_irq = 1'b1; it.addr = 3'd0; it.exp = {7'b0, e};
        sb.push_back(it);
        cyc(1'b1, 1'b0, 1'b0, 3'd0, 8'h00, 1'b1);
    endtask

    task automatic nop(input int n);
        for (int k = 0; k < n; k++) cyc(1'b1, 1'b0, 1'b0, 3'd0, 8'h00, 1'b0);
    endtask

    task automatic stall(input int n);
        for (int k = 0; k < n; k++) cyc(1'b0, 1'b0, 1'b0, 3'd0, 8'h00, 1'b0);
    endtask

    task automatic summary;
        if (!reported) begin
            reported = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
        end
    endtask

    initial begin
        repeat (160000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R2 watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        rd_chk(RA_A_LO, 8'h00, "R1");
        rd_chk(RA_FLAGS, 8'h00, "R1");
        rd_chk(RA_ENABLE, 8'h00, "R1");
        irq_chk(1'b1, "R1");
        rd_chk(RA_MODE, 8'h00, "R1");

        // R2 load one cycle after high write, R11 stall holds state
        wr_reg(RA_A_LO, 8'h10);
        wr_reg(RA_A_HI, 8'h00);
        nop(1);
        rd_chk(RA_A_LO, 8'h10, "R2");
        rd_chk(RA_A_LO, 8'h0F, "R2");
        stall(3);
        rd_chk(RA_A_LO, 8'h0E, "R11");

        // R3 / R5 / R7 one-shot, reload 2
        wr_reg(RA_A_LO, 8'h02);
        wr_reg(RA_A_HI, 8'h00);
        nop(4);
        rd_chk(RA_FLAGS, 8'h00, "R3");
        rd_chk(RA_FLAGS, 8'h01, "R3");
        rd_chk(RA_A_LO, 8'hFD, "R5");
        rd_chk(RA_FLAGS, 8'h00, "R7");
        nop(65536);
        rd_chk(RA_FLAGS, 8'h00, "R5");

        // R10 reload zero, then R6 clear by high write
        wr_reg(RA_A_LO, 8'h00);
        wr_reg(RA_A_HI, 8'h00);
        nop(1);
        rd_chk(RA_A_HI, 8'h00, "R10");
        rd_chk(RA_FLAGS, 8'h00, "R10");
        rd_chk(RA_FLAGS, 8'h01, "R10");
        wr_reg(RA_A_LO, 8'h00);
        wr_reg(RA_A_HI, 8'h40);
        rd_chk(RA_FLAGS, 8'h00, "R6");

        // R4 periodic, reload 3 -> period 5
        wr_reg(RA_MODE, 8'h01);
        wr_reg(RA_A_LO, 8'h03);
        wr_reg(RA_A_HI, 8'h00);
        nop(4);
        rd_chk(RA_FLAGS, 8'h00, "R4");
        rd_chk(RA_A_HI, 8'hFF, "R4");
        rd_chk(RA_FLAGS, 8'h01, "R4");
        rd_chk(RA_A_LO, 8'h02, "R4");
        rd_chk(RA_FLAGS, 8'h00, "R7");
        nop(1);
        rd_chk(RA_FLAGS, 8'h00, "R4");
        rd_chk(RA_FLAGS, 8'h01, "R4");
        rd_chk(RA_A_LO, 8'h02, "R4");

        // mid-run reset
        rst = 1'b1;
        nop(3);
        rst = 1'b0;
        rd_chk(RA_FLAGS, 8'h00, "R1");

        // R8 timer B one-shot, R9 enables
        wr_reg(RA_B_LO, 8'h02);
        wr_reg(RA_B_HI, 8'h00);
        nop(4);
        rd_chk(RA_FLAGS, 8'h00, "R8");
        rd_chk(RA_FLAGS, 8'h02, "R8");
        wr_reg(RA_ENABLE, 8'h82);
        irq_chk(1'b0, "R9");
        rd_chk(RA_ENABLE, 8'h02, "R9");
        rd_chk(RA_FLAGS, 8'h82, "R9");
        wr_reg(RA_ENABLE, 8'h02);
        irq_chk(1'b1, "R9");
        rd_chk(RA_B_LO, 8'hF7, "R8");
        rd_chk(RA_FLAGS, 8'h00, "R8");
        wr_reg(RA_ENABLE, 8'h83);
        rd_chk(RA_ENABLE, 8'h03, "R9");
        nop(65536);
        irq_chk(1'b1, "R8");
        rd_chk(RA_FLAGS, 8'h00, "R8");

        cyc(1'b0, 1'b0, 1'b0, 3'd0, 8'h00, 1'b0);
        nop(2);
        if (sb.size() != 0) begin
            checks++;
            errors++;
            $display("FAIL R2 unconsumed items actual=%0d expected=0", sb.size());
        end
        done = 1'b1;
        summary();
        $finish;
    end

endmodule